// File: doc/BRIEF.md
# Lane Metaframe Transmit Generator

This block produces the transmit word stream of one lane as a repeating sequence of fixed-length metaframes. Each metaframe opens with three control words: a synchronization word, a scrambler-state word and a skip word. Payload slots follow. The metaframe closes with a diagnostic word that reports the two-bit lane and link status and a CRC32 over the earlier words of the same metaframe. Each word leaves on a 64-bit bus together with a control flag that separates control words from user data. A start-of-metaframe strobe marks the first words of every metaframe.

Payload is pulled from a show-ahead transmit FIFO. The burst-enable input is sampled once, at the first slot of a metaframe, and that value decides how the whole metaframe is filled. When it is 0, every payload slot carries a skip word and the FIFO is never read. When it is 1, each payload slot reads one FIFO word. If the FIFO is empty in a payload slot, a skip word goes out in its place and the stream does not stall. The status input is sampled in the same cycle as burst-enable and appears in the diagnostic word that closes that metaframe.

Top module: `mfg_metaframe_gen`

## Requirements
- R1: While reset is asserted, and after it, until the first clock edge with reset released: word_o is 0, ctrl_o is 1, sof_o is 0 and fifo_rd_o is 0.
- R2: Slot k (0-based) of the metaframe is computed at clock edge k and appears on word_o after that edge. Slots are numbered modulo MF_LEN, and the first edge after reset release is slot 0. Slot 0 is the synchronization word 64'h78F678F678F678F6. Slot 1 is {6'b001010, SCRAM_SEED}. Slot 2 is the skip word 64'h1E00000000000000. Slot MF_LEN-1 is the diagnostic word. All four carry ctrl_o = 1.
- R3: sof_o is 1 exactly while slots 0 to SOF_LEN-1 are on word_o, where SOF_LEN is 2 or 3.
- R4: burst_en_i and stat_i are sampled only at the slot 0 edge. Changes at any other point do not affect the current metaframe.
- R5: With a sampled burst-enable of 0, fifo_rd_o stays 0 for the whole metaframe, and every payload slot (3 to MF_LEN-2) is the skip word with ctrl_o = 1.
- R6: With a sampled burst-enable of 1 and fifo_empty_i = 0 during a payload slot, fifo_rd_o is 1 combinationally before that slot's edge. fifo_data_i then appears on word_o after the edge with ctrl_o = 0.
- R7: With a sampled burst-enable of 1 and fifo_empty_i = 1 during a payload slot, fifo_rd_o is 0 and that slot is the skip word with ctrl_o = 1.
- R8: In the diagnostic word, bits [63:58] are 6'b011001 and bits [57:34] are zero. Bits [33:32] hold the status sampled at slot 0 of the same metaframe: bit 33 is lane up and bit 32 is link up.
- R9: Bits [31:0] of the diagnostic word are the CRC32 over slots 0 to MF_LEN-2 of the same metaframe. The CRC uses polynomial 32'h04C11DB7 and starts from all ones. It processes each word MSB first, with no reflection and no final inversion. The CRC restarts for every metaframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_en_i | input | 1 | Payload source select, sampled at slot 0 |
| stat_i | input | 2 | Lane/link status, sampled at slot 0 |
| fifo_empty_i | input | 1 | Transmit FIFO has no word |
| fifo_data_i | input | 64 | Head word of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Pop the FIFO head at this edge |
| word_o | output | 64 | Emitted word |
| ctrl_o | output | 1 | 1 = control word, 0 = user data |
| sof_o | output | 1 | Start-of-metaframe strobe |

## Verification
The assertions rely on two things about the inputs. First, fifo_data_i holds the head word whenever fifo_empty_i is low. Second, burst_en_i and stat_i stay stable for several cycles on either side of the strobe, so sampling them at slot 0 is unambiguous. The stimulus keeps to both. It changes burst-enable and status only at mid-metaframe, and it shows a fresh FIFO word only after a pop. The empty pattern varies between never, periodic and always, over several metaframes with both burst settings, so the reads, the skip substitution and the CRC restart are all covered.

// File: rtl/mfg_pkg.sv
package mfg_pkg;
    localparam int WORD_W = 64;
    localparam int CRC_W  = 32;

    typedef enum logic [2:0] {
        SL_SYNC,
        SL_SCRAM,
        SL_SKIP,
        SL_PAY,
        SL_DIAG
    } slot_e;

    localparam logic [WORD_W-1:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6;
    localparam logic [WORD_W-1:0] SKIP_WORD = 64'h1E00_0000_0000_0000;
    localparam logic [5:0]        SCRAM_TAG = 6'b001010;
    localparam logic [5:0]        DIAG_TAG  = 6'b011001;
    localparam logic [CRC_W-1:0]  CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0]  CRC_INIT  = 32'hFFFF_FFFF;

    // One 64-bit word through the CRC register, MSB first
    function automatic logic [CRC_W-1:0] crc32_step(input logic [CRC_W-1:0] c,
                                                    input logic [WORD_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            r = {r[CRC_W-2:0], 1'b0} ^ ((r[CRC_W-1] ^ d[i]) ? CRC_POLY : '0);
        end
        return r;
    endfunction

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              ctrl;
        logic              sof;
        logic              burst;
        logic [1:0]        stat;
    } gen_st_t;
endpackage

// File: rtl/mfg_slot_seq.sv
module mfg_slot_seq
    import mfg_pkg::*;
#(
    parameter int MF_LEN = 2048,
    localparam int CW = $clog2(MF_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    output slot_e         slot_o,
    output logic [CW-1:0] idx_o
);
    localparam logic [CW-1:0] LAST_IDX = CW'(MF_LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        unique case (cnt_q)
            CW'(0):   slot_o = SL_SYNC;
            CW'(1):   slot_o = SL_SCRAM;
            CW'(2):   slot_o = SL_SKIP;
            LAST_IDX: slot_o = SL_DIAG;
            default:  slot_o = SL_PAY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idx_o = cnt_q;
endmodule

// File: rtl/mfg_crc_acc.sv
module mfg_crc_acc
    import mfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr_i)     crc_d = CRC_INIT;
        else if (en_i) crc_d = crc32_step(crc_q, data_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= CRC_INIT;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/mfg_metaframe_gen.sv
module mfg_metaframe_gen
    import mfg_pkg::*;
#(
    parameter int          MF_LEN     = 2048,
    parameter int          SOF_LEN    = 2,
    parameter logic [57:0] SCRAM_SEED = 58'h0AB_CDEF_1234_5678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en_i,
    input  logic [1:0]        stat_i,
    input  logic              fifo_empty_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    output logic              fifo_rd_o,
    output logic [WORD_W-1:0] word_o,
    output logic              ctrl_o,
    output logic              sof_o
);
    localparam int CW = $clog2(MF_LEN);
    localparam logic [CW-1:0] SOF_IDX = CW'(SOF_LEN);

    slot_e            slot;
    logic [CW-1:0]    idx;
    logic [CRC_W-1:0] crc;
    gen_st_t          st_d, st_q;

    mfg_slot_seq #(.MF_LEN(MF_LEN)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot),
        .idx_o  (idx)
    );

    mfg_crc_acc crc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (slot == SL_DIAG),
        .en_i   (slot != SL_DIAG),
        .data_i (st_d.word),
        .crc_o  (crc)
    );

    always_comb begin
        st_d      = st_q;
        fifo_rd_o = 1'b0;
        st_d.sof  = (idx < SOF_IDX);
        st_d.ctrl = 1'b1;
        st_d.word = SKIP_WORD;
        unique case (slot)
            SL_SYNC: begin
                st_d.burst = burst_en_i;
                st_d.stat  = stat_i;
                st_d.word  = SYNC_WORD;
            end
            SL_SCRAM: st_d.word = {SCRAM_TAG, SCRAM_SEED};
            SL_SKIP:  st_d.word = SKIP_WORD;
            SL_PAY: begin
                if (st_q.burst && !fifo_empty_i) begin
                    fifo_rd_o = 1'b1;
                    st_d.word = fifo_data_i;
                    st_d.ctrl = 1'b0;
                end
            end
            SL_DIAG:  st_d.word = {DIAG_TAG, 24'h0, st_q.stat, crc};
            default:  st_d.word = SKIP_WORD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ctrl  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign ctrl_o = st_q.ctrl;
    assign sof_o  = st_q.sof;
endmodule

// File: rtl/mfg_metaframe_chk.sv
module mfg_metaframe_chk
    import mfg_pkg::*;
#(
    parameter int SOF_LEN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_empty_i,
    input logic [WORD_W-1:0] fifo_data_i,
    input logic              fifo_rd_o,
    input logic [WORD_W-1:0] word_o,
    input logic              ctrl_o,
    input logic              sof_o
);
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= '0;
        else if (sof_o) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    // R2
    sof_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_o) |-> (ctrl_o && word_o == SYNC_WORD));

    // R3
    sof_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sof_o) |-> (run_q == 3'(SOF_LEN)));

    // R7
    no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> !fifo_empty_i);

    // R6
    read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |=> (!ctrl_o && word_o == $past(fifo_data_i)));

    // R5
    data_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o |-> $past(fifo_rd_o));

    // R8
    diag_then_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o && word_o[63:58] == DIAG_TAG) |=> $rose(sof_o));
endmodule

bind mfg_metaframe_gen mfg_metaframe_chk #(.SOF_LEN(SOF_LEN)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_rd_o    (fifo_rd_o),
    .word_o       (word_o),
    .ctrl_o       (ctrl_o),
    .sof_o        (sof_o)
);

// File: tb/mfg_metaframe_gen_tb.sv
`timescale 1ns/1ps
module mfg_metaframe_gen_tb_top;
    localparam int          MF   = 12;
    localparam int          SL   = 3;
    localparam int          NF   = 8;
    localparam logic [57:0] SEED = 58'h155_0F0F_3C3C_A5A5;
    localparam logic [63:0] DBASE = 64'hA5A5_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        burst_en_i;
    logic [1:0]  stat_i;
    logic        fifo_empty_i;
    logic [63:0] fifo_data_i;
    logic        fifo_rd_o;
    logic [63:0] word_o;
    logic        ctrl_o;
    logic        sof_o;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mfg_metaframe_gen #(.MF_LEN(MF), .SOF_LEN(SL), .SCRAM_SEED(SEED)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_en_i   (burst_en_i),
        .stat_i       (stat_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_rd_o    (fifo_rd_o),
        .word_o       (word_o),
        .ctrl_o       (ctrl_o),
        .sof_o        (sof_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_model(input logic [31:0] c, input logic [63:0] d);
        for (int i = 63; i >= 0; i--) begin
            bit fb = c[31] ^ d[i];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    function automatic bit burst_pat(input int f);
        return (f % 3) != 1;
    endfunction

    function automatic bit empty_pat(input int f, input int s);
        case (f % 4)
            0:       return 1'b0;
            1:       return (s % 3) == 0;
            2:       return 1'b1;
            default: return (s % 2) == 1;
        endcase
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #1_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog expired act=0 exp=1");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] crc;
        logic [63:0] expw;
        logic        expc;
        logic        exp_rd;
        logic        bm;
        logic [1:0]  sm;
        int          pops;

        rst_n        = 1'b0;
        burst_en_i   = burst_pat(0);
        stat_i       = 2'd0;
        fifo_empty_i = 1'b0;
        fifo_data_i  = DBASE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(word_o == 64'h0, "R1 word", word_o, 64'h0);
        chk(ctrl_o == 1'b1, "R1 ctrl", 64'(ctrl_o), 64'h1);
        chk(sof_o == 1'b0, "R1 sof", 64'(sof_o), 64'h0);
        chk(fifo_rd_o == 1'b0, "R1 rd", 64'(fifo_rd_o), 64'h0);
        rst_n = 1'b1;

        crc  = 32'hFFFF_FFFF;
        pops = 0;
        bm   = 1'b0;
        sm   = 2'd0;
        for (int f = 0; f < NF; f++) begin
            for (int s = 0; s < MF; s++) begin
                // R4: next metaframe's controls change mid-frame only
                if (s == MF / 2) begin
                    burst_en_i = burst_pat(f + 1);
                    stat_i     = 2'((f + 1) % 4);
                end
                fifo_empty_i = empty_pat(f, s);
                fifo_data_i  = DBASE | 64'(pops);
                #1;
                if (s == 0) begin
                    bm = burst_en_i;
                    sm = stat_i;
                end
                exp_rd = bm && (s >= 3) && (s < MF - 1) && !fifo_empty_i;
                // R5 R6 R7: read strobe
                chk(fifo_rd_o == exp_rd, bm ? (fifo_empty_i ? "R7 rd" : "R6 rd") : "R5 rd",
                    64'(fifo_rd_o), 64'(exp_rd));
                expc = 1'b1;
                if (s == 0)           expw = 64'h78F6_78F6_78F6_78F6;
                else if (s == 1)      expw = {6'b001010, SEED};
                else if (s == 2)      expw = 64'h1E00_0000_0000_0000;
                else if (s == MF - 1) expw = {6'b011001, 24'h0, sm, crc};
                else if (exp_rd) begin
                    expw = fifo_data_i;
                    expc = 1'b0;
                end else              expw = 64'h1E00_0000_0000_0000;
                if (exp_rd) pops++;
                @(posedge clk);
                @(negedge clk);
                if (s == MF - 1) begin
                    // R8: header and status; R9: CRC field
                    chk(word_o[63:32] == expw[63:32], "R8 diag", word_o, expw);
                    chk(word_o[31:0] == expw[31:0], "R9 crc", 64'(word_o[31:0]), 64'(expw[31:0]));
                end else begin
                    chk(word_o == expw, (s < 3) ? "R2 word" : (bm ? "R6 word" : "R5 word"),
                        word_o, expw);
                end
                chk(ctrl_o == expc, "R2 ctrl", 64'(ctrl_o), 64'(expc));
                chk(sof_o == (s < SL), "R3 sof", 64'(sof_o), 64'(s < SL));
                if (s == MF - 1) crc = 32'hFFFF_FFFF;
                else             crc = crc_model(crc, expw);
            end
        end
        summary();
        $finish;
    end
endmodule